// File: doc/BRIEF.md
# Cascadable Bidirectional Column Data Sampler

This block collects one display line of gray-scale codes for a 240-column panel driver. On every rising clock edge it can accept three 6-bit dot codes. Which column group takes them is set by a one-hot sampling pointer. A start pulse launches the pointer, and it then walks across 80 groups in the direction chosen by a direction select. Once the scan is in progress, a cascade pulse leaves the block so that a second, identical stage continues the same line with no gap.

The two start-pulse pins work as a pair. The direction select decides which of them is the input and which one drives the cascade pulse out, and each pin has its own output enable. A strobe copies the collected line into an output latch of 240 codes, which feeds the conversion stage. The same strobe also idles the pointer, so no group captures again until a new start pulse arrives. A synchronous reset puts every register into a known zero state.

Top module: `col_sampler`

## Requirements
- R1: While `rst` is high at a clock edge, the pointer, the data register and the output latch are cleared. After reset `line_out` is all zero and both start-pulse outputs are low.
- R2: Dot d of `pix_in` occupies bits [6d+5:6d], with bit 0 as the LSB. Output position p (column p+1) occupies bits [6p+5:6p] of `line_out`.
- R3: With `dir_up` high, the start pulse is taken from `sp_r_in`. The k-th data clock after the start edge (k = 0..79) writes dot d into position 3k+d.
- R4: With `dir_up` low, the start pulse is taken from `sp_l_in`. The k-th data clock writes dot d into position 3(79-k)+2-d, so the line fills from column 240 toward column 1.
- R5: With `dir_up` high, `sp_l_oe`=1 and `sp_r_oe`=0. With it low, the reverse holds. A pin whose enable is low has its output held low.
- R6: The enabled start-pulse output is high for exactly one cycle, after the 80th rising edge counted from (and including) the edge that sampled the start pulse.
- R7: On a clock edge with `strobe` high, `line_out` takes the data register contents. Otherwise `line_out` holds, even while a new scan runs.
- R8: A strobe idles the pointer. The data register captures nothing on the strobe edge or afterwards, and no cascade pulse appears until a new start pulse. A start pulse on the same edge as the strobe is ignored.
- R9: A start pulse during a scan restarts the pointer at the first group. The abandoned scan produces no cascade pulse.
- R10: At most one pointer stage is active at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dir_up | input | 1 | Fill direction: 1 = column 1 toward 240, 0 = reverse |
| sp_r_in | input | 1 | Right start-pulse pin, input side |
| sp_r_out | output | 1 | Right start-pulse pin, output side |
| sp_r_oe | output | 1 | Right start-pulse pin output enable |
| sp_l_in | input | 1 | Left start-pulse pin, input side |
| sp_l_out | output | 1 | Left start-pulse pin, output side |
| sp_l_oe | output | 1 | Left start-pulse pin output enable |
| pix_in | input | 18 | Three 6-bit dot codes for the current group |
| strobe | input | 1 | Copies the line into the output latch and idles the pointer |
| line_out | output | 1440 | 240 latched 6-bit codes |

## Verification
The hardest state to reach is a half-filled data register whose pointer a strobe has killed. At that point the only visible evidence that capture stopped is what a later strobe reveals. The bench fills 40 groups, strobes with a start pulse on the same edge, and then clocks 80 more cycles of fresh data while it watches both cascade pins. A second strobe must then show the partial line unchanged. Restart mid-scan and latch hold during a full unstrobed scan are reached the same way: through the cascade pins and the contents the next strobe exposes.

// File: rtl/cs_pkg.sv
package cs_pkg;
   // fill order selected by the direction input
   typedef enum logic {
      FILL_FROM_LAST  = 1'b0,
      FILL_FROM_FIRST = 1'b1
   } fill_dir_e;
endpackage

// File: rtl/cs_scan_ptr.sv
module cs_scan_ptr #(
   parameter int GROUPS = 80
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              strobe,
   output logic [GROUPS-1:0] ptr,
   output logic              casc
);
   generate
      if (GROUPS < 2) begin : g_bad_groups
         $error("cs_scan_ptr: GROUPS must be at least 2");
      end
   endgenerate

   localparam logic [GROUPS-1:0] FIRST = GROUPS'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr  <= '0;
         casc <= 1'b0;
      end else if (strobe) begin
         ptr  <= '0;
         casc <= 1'b0;
      end else if (start) begin
         ptr  <= FIRST;
         casc <= 1'b0;
      end else begin
         ptr  <= {ptr[GROUPS-2:0], 1'b0};
         casc <= ptr[GROUPS-2];
      end
   end

   // R10
   ptr_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(ptr));
   // R6
   casc_width_chk: assert property (@(posedge clk) disable iff (rst) casc |=> !casc);
   // R8
   strobe_idle_chk: assert property (@(posedge clk) disable iff (rst) strobe |=> (ptr == '0));
endmodule

// File: rtl/cs_line_reg.sv
module cs_line_reg
   import cs_pkg::*;
#(
   parameter int GROUPS = 80,
   parameter int DOTS   = 3,
   parameter int DW     = 6
) (
   input  logic                        clk,
   input  logic                        rst,
   input  fill_dir_e                   dir,
   input  logic                        strobe,
   input  logic [GROUPS-1:0]           ptr,
   input  logic [DOTS*DW-1:0]          pix,
   output logic [GROUPS*DOTS*DW-1:0]   regs
);
   generate
      for (genvar g = 0; g < GROUPS; g++) begin : g_grp
         logic en;
         assign en = ~strobe &
                     ((dir == FILL_FROM_FIRST) ? ptr[g] : ptr[GROUPS-1-g]);
         for (genvar d = 0; d < DOTS; d++) begin : g_dot
            logic [DW-1:0] q;
            always_ff @(posedge clk) begin
               if (rst)
                  q <= '0;
               else if (en)
                  q <= (dir == FILL_FROM_FIRST) ? pix[d*DW +: DW]
                                                : pix[(DOTS-1-d)*DW +: DW];
            end
            assign regs[(g*DOTS+d)*DW +: DW] = q;
         end
      end
   endgenerate
endmodule

// File: rtl/cs_out_latch.sv
module cs_out_latch #(
   parameter int W = 1440
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (load)
         q <= d;
   end

   // R7
   latch_hold_chk: assert property (@(posedge clk) disable iff (rst) !load |=> $stable(q));
   // R7
   latch_load_chk: assert property (@(posedge clk) disable iff (rst) load |=> (q == $past(d)));
endmodule

// File: rtl/col_sampler.sv
module col_sampler
   import cs_pkg::*;
#(
   parameter int GROUPS = 80,
   parameter int DOTS   = 3,
   parameter int DW     = 6,
   localparam int PIX_W  = DOTS * DW,
   localparam int LINE_W = GROUPS * PIX_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              dir_up,
   input  logic              sp_r_in,
   output logic              sp_r_out,
   output logic              sp_r_oe,
   input  logic              sp_l_in,
   output logic              sp_l_out,
   output logic              sp_l_oe,
   input  logic [PIX_W-1:0]  pix_in,
   input  logic              strobe,
   output logic [LINE_W-1:0] line_out
);
   generate
      if (DOTS < 1 || DW < 1) begin : g_bad_shape
         $error("col_sampler: DOTS and DW must be positive");
      end
   endgenerate

   fill_dir_e          dir;
   logic               start;
   logic               casc;
   logic [GROUPS-1:0]  ptr;
   logic [LINE_W-1:0]  regs;

   assign dir      = dir_up ? FILL_FROM_FIRST : FILL_FROM_LAST;
   assign start    = dir_up ? sp_r_in : sp_l_in;
   assign sp_l_oe  = dir_up;
   assign sp_r_oe  = ~dir_up;
   assign sp_l_out = dir_up & casc;
   assign sp_r_out = ~dir_up & casc;

   cs_scan_ptr #(.GROUPS(GROUPS)) i_ptr (
      .clk(clk), .rst(rst), .start(start), .strobe(strobe),
      .ptr(ptr), .casc(casc)
   );

   cs_line_reg #(.GROUPS(GROUPS), .DOTS(DOTS), .DW(DW)) i_reg (
      .clk(clk), .rst(rst), .dir(dir), .strobe(strobe),
      .ptr(ptr), .pix(pix_in), .regs(regs)
   );

   cs_out_latch #(.W(LINE_W)) i_latch (
      .clk(clk), .rst(rst), .load(strobe), .d(regs), .q(line_out)
   );

   // R5
   r_pin_quiet_chk: assert property (@(posedge clk) disable iff (rst) !sp_r_oe |-> !sp_r_out);
   // R5
   l_pin_quiet_chk: assert property (@(posedge clk) disable iff (rst) !sp_l_oe |-> !sp_l_out);
endmodule

// File: tb/test_col_sampler.sv
module test_col_sampler;
   localparam int G  = 80;
   localparam int N  = 3;
   localparam int W  = 6;
   localparam int PW = N * W;
   localparam int LW = G * PW;
   localparam int P  = G * N;

   // {dir, seed[5:0], expected r_oe, expected l_oe}
   localparam logic [8:0] VEC [4] = '{
      {1'b1, 6'h00, 1'b0, 1'b1},
      {1'b0, 6'h11, 1'b1, 1'b0},
      {1'b1, 6'h2A, 1'b0, 1'b1},
      {1'b0, 6'h3F, 1'b1, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          dir_up = 1'b1;
   logic          sp_r_in = 1'b0;
   logic          sp_l_in = 1'b0;
   logic          strobe = 1'b0;
   logic [PW-1:0] pix_in = '0;
   logic          sp_r_out, sp_r_oe, sp_l_out, sp_l_oe;
   logic [LW-1:0] line_out;

   int checks = 0;
   int fails  = 0;

   logic [W-1:0] reg_m   [P];
   logic [W-1:0] latch_m [P];

   always #5 clk = ~clk;

   col_sampler i_col_sampler (
      .clk(clk), .rst(rst), .dir_up(dir_up),
      .sp_r_in(sp_r_in), .sp_r_out(sp_r_out), .sp_r_oe(sp_r_oe),
      .sp_l_in(sp_l_in), .sp_l_out(sp_l_out), .sp_l_oe(sp_l_oe),
      .pix_in(pix_in), .strobe(strobe), .line_out(line_out)
   );

   function automatic logic [W-1:0] pv(input int k, input int d, input logic [W-1:0] seed);
      int v;
      v = (k * 3 + d) * 5 + int'(seed);
      return v[W-1:0];
   endfunction

   task automatic chk(input bit ok, input string msg);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s", msg);
      end
   endtask

   task automatic check_line(input string req);
      int bad = 0;
      int first = -1;
      for (int p = 0; p < P; p++)
         if (line_out[p*W +: W] !== latch_m[p]) begin
            bad++;
            if (first < 0) first = p;
         end
      if (first < 0)
         chk(1'b1, req);
      else
         chk(1'b0, $sformatf("%s line pos %0d actual %0h expected %0h (%0d bad)",
                             req, first, line_out[first*W +: W], latch_m[first], bad));
   endtask

   task automatic give_start(input bit dir, input bit with_strobe);
      @(negedge clk);
      dir_up  = dir;
      sp_r_in = dir;
      sp_l_in = !dir;
      strobe  = with_strobe;
      pix_in  = {PW{1'b1}};
   endtask

   // runs nsteps data clocks; casc expected after the 80th edge of a full scan
   task automatic run_scan(input bit dir, input logic [W-1:0] seed, input int nsteps,
                           input bit update, input string req);
      int bad = 0;
      logic act, oth;
      for (int k = 0; k < nsteps; k++) begin
         @(negedge clk);
         sp_r_in = 1'b0; sp_l_in = 1'b0; strobe = 1'b0;
         if (k > 0) begin
            act = dir ? sp_l_out : sp_r_out;
            oth = dir ? sp_r_out : sp_l_out;
            if (act !== (k - 1 == G - 2) || oth !== 1'b0) bad++;
         end
         for (int d = 0; d < N; d++) begin
            pix_in[d*W +: W] = pv(k, d, seed);
            if (update) begin
               int g = dir ? k : G - 1 - k;
               reg_m[3*g + (dir ? d : N - 1 - d)] = pv(k, d, seed);
            end
         end
      end
      if (nsteps == G) begin
         @(negedge clk);
         act = dir ? sp_l_out : sp_r_out;
         oth = dir ? sp_r_out : sp_l_out;
         if (act !== 1'b0 || oth !== 1'b0) bad++;
         chk(bad == 0, $sformatf("%s cascade timing actual %0d bad cycles expected 0", req, bad));
      end
   endtask

   task automatic do_strobe(input bit with_start, input bit dir);
      @(negedge clk);
      sp_r_in = with_start & dir;
      sp_l_in = with_start & !dir;
      strobe  = 1'b1;
      @(negedge clk);
      strobe = 1'b0; sp_r_in = 1'b0; sp_l_in = 1'b0;
      for (int p = 0; p < P; p++) latch_m[p] = reg_m[p];
   endtask

   initial begin
      #2_000_000;
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      for (int p = 0; p < P; p++) begin reg_m[p] = '0; latch_m[p] = '0; end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      check_line("R1 reset");
      chk(sp_r_out === 1'b0 && sp_l_out === 1'b0,
          $sformatf("R1 outs actual %b%b expected 00", sp_r_out, sp_l_out));

      // table of full scans: R2 R3 R4 R5 R6 R7 R10
      for (int i = 0; i < 4; i++) begin
         bit dir;
         logic [W-1:0] seed;
         dir  = VEC[i][8];
         seed = VEC[i][7:2];
         give_start(dir, 1'b0);
         #1;
         chk(sp_r_oe === VEC[i][1] && sp_l_oe === VEC[i][0],
             $sformatf("R5 oe actual %b%b expected %b%b", sp_r_oe, sp_l_oe, VEC[i][1], VEC[i][0]));
         run_scan(dir, seed, G, 1'b1, dir ? "R6 up" : "R6 down");
         do_strobe(1'b0, dir);
         check_line(dir ? "R3 R2 R10 fill up" : "R4 R2 R10 fill down");
      end

      // R7: a full unstrobed scan leaves the latch alone
      give_start(1'b1, 1'b0);
      run_scan(1'b1, 6'h05, G, 1'b1, "R6 hold scan");
      check_line("R7 hold");
      do_strobe(1'b0, 1'b1);
      check_line("R7 load");

      // R9: restart mid scan
      give_start(1'b0, 1'b0);
      run_scan(1'b0, 6'h21, 30, 1'b0, "R9 partial");
      give_start(1'b0, 1'b0);
      run_scan(1'b0, 6'h33, G, 1'b1, "R9 restart");
      do_strobe(1'b0, 1'b0);
      check_line("R9 restart line");

      // R8: strobe during scan (with start on same edge) idles the pointer
      give_start(1'b1, 1'b0);
      run_scan(1'b1, 6'h17, 40, 1'b1, "R8 partial");
      do_strobe(1'b1, 1'b1);
      check_line("R8 first strobe");
      begin
         int bad = 0;
         for (int k = 0; k < G; k++) begin
            @(negedge clk);
            if (sp_r_out !== 1'b0 || sp_l_out !== 1'b0) bad++;
            for (int d = 0; d < N; d++) pix_in[d*W +: W] = pv(k, d, 6'h2C);
         end
         chk(bad == 0, $sformatf("R8 cascade after strobe actual %0d cycles expected 0", bad));
      end
      do_strobe(1'b0, 1'b1);
      check_line("R8 no capture after strobe");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule